// File: doc/BRIEF.md
# Re-centering Elastic Bit Buffer

This block carries a serial NRZ bit stream from a framer-side write clock into an on-chip reference read clock. Both clocks run at the same nominal rate, but their phase may wander within a bounded window. The block holds the stream in a small circular store. Write and read pointers cross between the domains as Gray code, so slow phase drift is absorbed without losing or repeating any bit.

After each recenter, the buffer is restarted with the read side trailing the write side by about half the store. A recenter comes from a one-cycle request pulse in the reference domain, or from the high-to-low transition of the loss-of-lock status. While the read side waits for the store to fill, the output is forced to 0. A write that finds the store full, or a read that finds it empty, sets a sticky error bit that only a recenter clears. For plesiochronous data a static bypass input routes the registered input bit straight to the output, and no error is raised while bypass is set.

Top module: `elastic_recenter_fifo`

## Requirements
- R1: While reset is asserted, and once it is released, `dout` is 0 and `err` is 0.
- R2: Bits captured on rising edges of `wclk` appear on `dout`, registered on rising edges of `rclk`, in arrival order with no bit lost, repeated or inverted.
- R3: On the first `rclk` edge after a recenter, `dout` becomes 0 and stays 0 while the store refills. Streaming then resumes, with latency from input to output between 5 and 13 read cycles.
- R4: Accumulated phase drift of up to 3 bit periods in either direction after a recenter leaves `err` at 0 and the stream intact.
- R5: A write clock that gains about 8 bit periods on the read clock overflows the store and sets `err` to 1.
- R6: A write clock that loses about 8 bit periods against the read clock underflows the store and sets `err` to 1.
- R7: Once set, `err` stays 1 regardless of further drift, until a recenter occurs.
- R8: A one-cycle high pulse on `recenter`, sampled on `rclk`, clears `err` and restarts the buffer centred, after which the stream is again intact.
- R9: A high-to-low transition of `lol` acts as a recenter. A low-to-high transition has no effect on `err`.
- R10: With `bypass` at 1, `dout` equals the value of `din` captured on the latest rising edge of `wclk`, and `err` is not set by drift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write (framer-side) clock |
| rclk | input | 1 | Reference read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| din | input | 1 | Serial NRZ data, captured on rising `wclk` |
| bypass | input | 1 | Static mode: 1 routes `din` around the store |
| recenter | input | 1 | One-cycle recenter request in the `rclk` domain |
| lol | input | 1 | Loss-of-lock status; its falling edge recenters |
| dout | output | 1 | Serial NRZ data out |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
A pointer that restarts at the wrong place shows at the ports as a latency outside the centred window, or as a stream with bits displaced. This is visible in the first marker word sent after each recenter. A broken Gray step or a corrupt synchronized pointer makes one side judge the store full or empty when it is not. That raises `err` within a few read cycles of drift that should have been tolerated, or leaves it clear after a drift of 8 bits. A sticky bit that clears too early shows as `err` dropping during the hold after a fault, before any recenter has been issued.

// File: rtl/efr_pkg.sv
package efr_pkg;

  // Read-side sequencing after a recenter
  typedef enum logic [1:0] {
    RS_HOLD = 2'd0,  // both pointers parked at zero
    RS_FILL = 2'd1,  // writer running, reader waiting for fill level
    RS_RUN  = 2'd2   // steady streaming
  } rd_state_e;

endpackage

// File: rtl/efr_rstsync.sv
module efr_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] rst_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_q <= 2'b00;
    end else begin
      rst_q <= {rst_q[0], 1'b1};
    end
  end

  assign srst_n = rst_q[1];

endmodule

// File: rtl/efr_sync.sv
module efr_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/efr_wside.sv
module efr_wside #(
  parameter int AW = 4
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              din,
  input  logic              hold_s,
  input  logic [AW:0]       rgray_s,
  output logic [AW:0]       wgray_o,
  output logic              ovf_o,
  output logic              byp_o,
  output logic [(1<<AW)-1:0] mem_o
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DEPTH-1:0] mem_q, mem_d;
  logic [PW-1:0]    wbin_q, wbin_d, wgray_q, wgray_d;
  logic [PW-1:0]    rbin_s, occ;
  logic             ovf_q, ovf_d, byp_q;
  logic             wr_en, full;

  always_comb begin
    wr_en   = !hold_s;
    rbin_s  = g2b(rgray_s);
    occ     = wbin_q - rbin_s;
    full    = occ[PW-1];
    mem_d   = mem_q;
    if (wr_en) mem_d[wbin_q[AW-1:0]] = din;
    wbin_d  = wr_en ? (wbin_q + PW'(1)) : '0;
    wgray_d = wbin_d ^ (wbin_d >> 1);
    ovf_d   = hold_s ? 1'b0 : (ovf_q | full);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      mem_q   <= '0;
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
      byp_q   <= 1'b0;
    end else begin
      mem_q   <= mem_d;
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      ovf_q   <= ovf_d;
      byp_q   <= din;
    end
  end

  assign wgray_o = wgray_q;
  assign ovf_o   = ovf_q;
  assign byp_o   = byp_q;
  assign mem_o   = mem_q;

  AST_WGRAY_ONE_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    !hold_s |=> ($countones(wgray_q ^ $past(wgray_q)) == 1)); // R2

  AST_OVF_STICKY: assert property (@(posedge wclk) disable iff (!wrst_n)
    (ovf_q && !hold_s) |=> ovf_q); // R7

endmodule

// File: rtl/efr_rside.sv
module efr_rside
  import efr_pkg::*;
#(
  parameter int AW        = 4,
  parameter int HOLD_CYC  = 8,
  parameter int START_LVL = 6
) (
  input  logic               rclk,
  input  logic               rrst_n,
  input  logic               rc_evt,
  input  logic               bypass,
  input  logic [AW:0]        wgray_s,
  input  logic               ovf_s,
  input  logic [(1<<AW)-1:0] mem_i,
  output logic               hold_o,
  output logic [AW:0]        rgray_o,
  output logic               dout_o,
  output logic               err_o
);

  localparam int PW = AW + 1;
  localparam int CW = $clog2(HOLD_CYC + 1);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  rd_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d, wbin_s, occ;
  logic          dout_q, dout_d, err_q, err_d;
  logic          run_en, underflow;

  always_comb begin
    wbin_s    = g2b(wgray_s);
    occ       = wbin_s - rbin_q;
    run_en    = (st_q == RS_RUN);
    underflow = run_en && (occ == '0);
    st_d      = st_q;
    cnt_d     = cnt_q;
    rbin_d    = rbin_q;
    dout_d    = 1'b0;
    err_d     = err_q;
    unique case (st_q)
      RS_HOLD: begin
        if (cnt_q != '0)        cnt_d = cnt_q - CW'(1);
        else if (wbin_s == '0)  st_d  = RS_FILL;
      end
      RS_FILL: begin
        if (wbin_s == PW'(START_LVL)) st_d = RS_RUN;
      end
      RS_RUN: begin
        dout_d = mem_i[rbin_q[AW-1:0]];
        rbin_d = rbin_q + PW'(1);
      end
      default: st_d = RS_HOLD;
    endcase
    if (run_en && !bypass && (underflow || ovf_s)) err_d = 1'b1;
    if (rc_evt) begin
      st_d   = RS_HOLD;
      cnt_d  = CW'(HOLD_CYC);
      rbin_d = '0;
      dout_d = 1'b0;
      err_d  = 1'b0;
    end
    rgray_d = rbin_d ^ (rbin_d >> 1);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      st_q    <= RS_HOLD;
      cnt_q   <= CW'(HOLD_CYC);
      rbin_q  <= '0;
      rgray_q <= '0;
      dout_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      dout_q  <= dout_d;
      err_q   <= err_d;
    end
  end

  assign hold_o  = (st_q == RS_HOLD);
  assign rgray_o = rgray_q;
  assign dout_o  = dout_q;
  assign err_o   = err_q;

  AST_ERR_STICKY: assert property (@(posedge rclk) disable iff (!rrst_n)
    (err_q && !rc_evt) |=> err_q); // R7

  AST_RECENTER_CLEARS: assert property (@(posedge rclk) disable iff (!rrst_n)
    rc_evt |=> (!err_q && !dout_q)); // R8

  AST_BYPASS_NO_ERR: assert property (@(posedge rclk) disable iff (!rrst_n)
    (bypass && !err_q) |=> !err_q); // R10

endmodule

// File: rtl/elastic_recenter_fifo.sv
module elastic_recenter_fifo #(
  parameter int AW          = 4,
  parameter int HOLD_CYC    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic wclk,
  input  logic rclk,
  input  logic rst_n,
  input  logic din,
  input  logic bypass,
  input  logic recenter,
  input  logic lol,
  output logic dout,
  output logic err
);

  localparam int DEPTH     = 1 << AW;
  localparam int PW        = AW + 1;
  localparam int START_LVL = DEPTH / 2 - SYNC_STAGES;

  logic             wrst_n, rrst_n;
  logic             hold_r, hold_w;
  logic [PW-1:0]    wgray_w, wgray_r, rgray_r, rgray_w;
  logic             ovf_w, ovf_r, byp_w;
  logic [DEPTH-1:0] mem_w;
  logic             lol_s, lol_q, rc_evt, fifo_dout;

  efr_rstsync i_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wrst_n));
  efr_rstsync i_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rrst_n));

  efr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_lol_sync (
    .clk(rclk), .rst_n(rrst_n), .d(lol), .q(lol_s));

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) lol_q <= 1'b0;
    else         lol_q <= lol_s;
  end

  assign rc_evt = recenter | (lol_q & ~lol_s);

  efr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_hold_sync (
    .clk(wclk), .rst_n(wrst_n), .d(hold_r), .q(hold_w));

  efr_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_w), .q(wgray_r));

  efr_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_r), .q(rgray_w));

  efr_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ovf_sync (
    .clk(rclk), .rst_n(rrst_n), .d(ovf_w), .q(ovf_r));

  efr_wside #(.AW(AW)) i_wside (
    .wclk(wclk), .wrst_n(wrst_n), .din(din), .hold_s(hold_w),
    .rgray_s(rgray_w), .wgray_o(wgray_w), .ovf_o(ovf_w),
    .byp_o(byp_w), .mem_o(mem_w));

  efr_rside #(.AW(AW), .HOLD_CYC(HOLD_CYC), .START_LVL(START_LVL)) i_rside (
    .rclk(rclk), .rrst_n(rrst_n), .rc_evt(rc_evt), .bypass(bypass),
    .wgray_s(wgray_r), .ovf_s(ovf_r), .mem_i(mem_w),
    .hold_o(hold_r), .rgray_o(rgray_r), .dout_o(fifo_dout), .err_o(err));

  assign dout = bypass ? byp_w : fifo_dout;

endmodule

// File: tb/test_elastic_recenter_fifo.sv
module test_elastic_recenter_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int PRE  = 30;
  localparam int CAPN = PRE + 32 + PRE;
  localparam int NPAT = 6;
  localparam logic [31:0] PATS [NPAT] = '{
    32'h8000_0001, 32'hA5A5_5A5A, 32'hFFFF_FFFF,
    32'h8421_0842, 32'hC0FF_EE01, 32'hB00B_1E55 };

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  logic rst_n, din, bypass, recenter, lol, dout, err;
  int   whalf = CLK_PERIOD / 2;
  int   n_run = 0;
  int   n_fail = 0;

  elastic_recenter_fifo i_elastic_recenter_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .bypass(bypass),
    .recenter(recenter), .lol(lol), .dout(dout), .err(err));

  always begin
    #(whalf) wclk = ~wclk;
  end

  initial begin
    #3;
    forever #(CLK_PERIOD / 2) rclk = ~rclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  task automatic drift(input int half, input int ncyc);
    whalf = half;
    repeat (ncyc) @(posedge wclk);
    whalf = CLK_PERIOD / 2;
  endtask

  task automatic pulse_recenter();
    @(negedge rclk) recenter = 1'b1;
    @(negedge rclk) recenter = 1'b0;
  endtask

  // Sends a marker word framed by zeros and checks it arrives intact
  task automatic run_pattern(input logic [31:0] pat, input string req, input bit chk_lat);
    logic cap [CAPN];
    int   f = -1;
    int   mism = 0;
    fork
      begin
        for (int i = 0; i < PRE; i++) begin @(negedge wclk) din = 1'b0; end
        for (int i = 31; i >= 0; i--) begin @(negedge wclk) din = pat[i]; end
        for (int i = 0; i < PRE; i++) begin @(negedge wclk) din = 1'b0; end
      end
      begin
        for (int i = 0; i < CAPN; i++) begin @(negedge rclk) cap[i] = dout; end
      end
    join
    for (int i = 0; i < CAPN; i++) if (f < 0 && cap[i] === 1'b1) f = i;
    chk(f >= 0, {req, " marker seen"}, f, PRE + 9);
    if (f >= 0) begin
      if (chk_lat) chk((f - PRE) >= 5 && (f - PRE) <= 13, "R3 centred latency", f - PRE, 9);
      for (int j = 0; j < 32; j++) begin
        if (f + j >= CAPN || cap[f + j] !== pat[31 - j]) mism++;
      end
      chk(mism == 0, {req, " stream intact"}, mism, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge rclk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; din = 1'b0; bypass = 1'b0; recenter = 1'b0; lol = 1'b0;
    repeat (5) @(negedge rclk);
    chk(dout === 1'b0, "R1 dout in reset", dout, 0);
    chk(err === 1'b0, "R1 err in reset", err, 0);
    @(negedge rclk) rst_n = 1'b1;
    repeat (60) @(negedge rclk);
    chk(err === 1'b0, "R1 err after start", err, 0);

    // Table of marker words, each also the expected output word
    for (int p = 0; p < NPAT; p++) run_pattern(PATS[p], "R2", 1'b1);
    chk(err === 1'b0, "R2 no error while streaming", err, 0);

    // R3: output forced to zero right after a recenter
    begin
      int nz = 0;
      @(negedge wclk) din = 1'b1;
      repeat (20) @(negedge rclk);
      pulse_recenter();
      for (int i = 0; i < 8; i++) begin
        if (i > 0) @(negedge rclk);
        if (dout !== 1'b0) nz++;
      end
      chk(nz == 0, "R3 zero after recenter", nz, 0);
      repeat (40) @(negedge rclk);
      chk(dout === 1'b1, "R3 streaming resumes", dout, 1);
      @(negedge wclk) din = 1'b0;
    end

    // R4: tolerated drift in both directions
    repeat (40) @(negedge rclk);
    drift(CLK_PERIOD / 2 - 1, 15);          // write gains 3 bits
    repeat (20) @(negedge rclk);
    run_pattern(32'h9C3E_71A5, "R4 drift ahead", 1'b0);
    chk(err === 1'b0, "R4 err after +3 drift", err, 0);
    drift(CLK_PERIOD / 2 + 1, 30);          // net 3 bits behind
    repeat (20) @(negedge rclk);
    run_pattern(32'hD2B4_0F1E, "R4 drift behind", 1'b0);
    chk(err === 1'b0, "R4 err after -3 drift", err, 0);

    // R5 / R7: overflow, then stickiness
    pulse_recenter();
    repeat (60) @(negedge rclk);
    drift(CLK_PERIOD / 2 - 1, 40);
    repeat (20) @(negedge rclk);
    chk(err === 1'b1, "R5 overflow sets err", err, 1);
    drift(CLK_PERIOD / 2 + 1, 40);
    repeat (30) @(negedge rclk);
    chk(err === 1'b1, "R7 err held after drift reversal", err, 1);

    // R8: recenter pulse clears and recentres
    pulse_recenter();
    @(negedge rclk);
    chk(err === 1'b0, "R8 recenter clears err", err, 0);
    repeat (60) @(negedge rclk);
    run_pattern(32'hE817_4C93, "R8", 1'b1);
    chk(err === 1'b0, "R8 err after restart", err, 0);

    // R6: underflow
    drift(CLK_PERIOD / 2 + 1, 40);
    repeat (20) @(negedge rclk);
    chk(err === 1'b1, "R6 underflow sets err", err, 1);

    // R9: loss-of-lock edges
    @(negedge rclk) lol = 1'b1;
    repeat (10) @(negedge rclk);
    chk(err === 1'b1, "R9 rising lol leaves err", err, 1);
    @(negedge rclk) lol = 1'b0;
    repeat (10) @(negedge rclk);
    chk(err === 1'b0, "R9 falling lol clears err", err, 0);
    repeat (60) @(negedge rclk);
    run_pattern(32'hF00D_A11C, "R9", 1'b1);

    // R10: bypass path and error suppression
    begin
      logic [15:0] bp = 16'b1011_0010_1110_0101;
      logic prev = 1'b0;
      int   mism = 0;
      @(negedge wclk) bypass = 1'b1;
      for (int i = 0; i < 16; i++) begin
        @(negedge wclk);
        if (i > 0 && dout !== prev) mism++;
        din  = bp[i];
        prev = bp[i];
      end
      @(negedge wclk);
      if (dout !== prev) mism++;
      chk(mism == 0, "R10 bypass follows din", mism, 0);
      din = 1'b0;
      drift(CLK_PERIOD / 2 + 1, 40);
      repeat (20) @(negedge rclk);
      chk(err === 1'b0, "R10 no err in bypass", err, 0);
      @(negedge rclk) bypass = 1'b0;
      pulse_recenter();
      repeat (60) @(negedge rclk);
      run_pattern(32'hA0B1_C2D3, "R10 after bypass", 1'b1);
      chk(err === 1'b0, "R10 err clean after bypass", err, 0);
    end

    finish_up();
  end

endmodule